// File: doc/BRIEF.md
# Presettable Johnson Frequency Divider

A five-stage twisted-ring counter that divides its clock by a ratio N fixed at elaboration, anywhere from 2 to 10. All five stage values are visible as outputs. A divided clock is taken from stage K, where K = ceil(N/2). On each rising edge the stages shift by one place and stage 1 takes a feedback bit. For an even N that bit is the inverse of stage K. For an odd N it is the NAND of stages K and K-1.

A synchronous clear forces every stage to zero. A synchronous load copies a 5-bit preset word into the stages. The feedback path also carries lock-out protection: whenever the first K stages hold a pattern outside the legal sequence, the counter shifts in zeros until the pattern becomes legal. Any starting state therefore settles into the intended cycle.

Top module: `johnson_divn`

## Requirements
- R1: On a rising edge with neither clear nor load asserted, stage i+1 takes the previous value of stage i for i = 1..4 (q[i] takes old q[i-1]).
- R2: After a clear, stage 1 (q[0]) goes high on the first shift edge. It stays high for ceil(N/2) edges, then low for floor(N/2) edges, and repeats with period N.
- R3: `clr` is sampled on the rising edge and drives all five stages to 0 on that edge. It wins over `load`.
- R4: A rising edge with `load` high and `clr` low copies `preset[i]` into stage `q[i]` for each of the five bits.
- R5: `div_out` equals stage K, bit q[K-1]. Once the counter is in its legal cycle, `div_out` repeats with period N and is high for ceil(N/2) of every N clocks.
- R6: From any of the 32 loaded states, within K+1 shift edges the first K stages show at most one change between neighbouring bits. For odd N they are also not all zero. They stay that way on every later edge.
- R7: The ratio parameter chooses the feedback. Even N uses the inverted stage N/2. Odd N uses the NAND of stages K and K-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| clr | input | 1 | Synchronous clear, active high |
| load | input | 1 | Synchronous preset load, active high |
| preset | input | 5 | Preset word, bit i goes to stage i+1 |
| q | output | 5 | Registered stage outputs, q[0] is stage 1 |
| div_out | output | 1 | Divided clock, stage K |

## Verification
Clear, load and every shift are visible one rising edge after the inputs that cause them. The scoreboard therefore tags each expected stage word with the cycle after its stimulus. The monitor compares at the following falling edge. Recovery is judged only after six shift edges, which is at least K+1 for every ratio. The period and duty checks then use a 20-clock window that starts after that settling time. Nine counters, one per ratio, share the same stimulus, so each clear, load and start state exercises every ratio in the same cycle.

// File: rtl/johnson_divn_pkg.sv
package johnson_divn_pkg;

    localparam int STAGES = 5;

    typedef logic [STAGES-1:0] stage_vec_t;

    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2
    } ring_op_e;

    typedef struct packed {
        ring_op_e   op;
        stage_vec_t word;
        logic       din;
    } ring_step_t;

    // stage that closes the loop and drives the divided output
    function automatic int tap_of(int ratio);
        return (ratio + 1) / 2;
    endfunction

    function automatic bit odd_ratio(int ratio);
        return (ratio % 2) == 1;
    endfunction

    // legal loop pattern: one boundary at most, never all-zero for odd ratios
    function automatic bit loop_legal(stage_vec_t v, int ratio);
        int w;
        int changes;
        bit any_one;
        w = tap_of(ratio);
        changes = 0;
        any_one = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (i < w) any_one = any_one | v[i];
            if (i < w - 1 && v[i] != v[i+1]) changes++;
        end
        if (changes > 1) return 1'b0;
        if (odd_ratio(ratio) && !any_one) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/johnson_divn_fb.sv
module johnson_divn_fb
    import johnson_divn_pkg::*;
#(
    parameter int DIV_N = 10
) (
    input  stage_vec_t q,
    output logic       din
);
    localparam int  K     = tap_of(DIV_N);
    localparam bit  ODD   = odd_ratio(DIV_N);
    localparam int  NPAIR = K - 1 - (ODD ? 1 : 0);

    logic base;
    logic hazard;

    generate
        if (ODD) begin : g_odd
            assign base = ~(q[K-1] & q[K-2]);
        end else begin : g_even
            assign base = ~q[K-1];
        end
    endgenerate

    // a rising boundary inside the loop marks an illegal pattern: shift zeros
    always_comb begin
        hazard = 1'b0;
        for (int i = 0; i < NPAIR; i++) begin
            hazard = hazard | (~q[i] & q[i+1]);
        end
    end

    assign din = base & ~hazard;

endmodule

// File: rtl/johnson_divn_ctrl.sv
module johnson_divn_ctrl
    import johnson_divn_pkg::*;
(
    input  logic       clr,
    input  logic       load,
    input  stage_vec_t preset,
    input  logic       din,
    output ring_step_t step
);
    always_comb begin
        step.word = preset;
        step.din  = din;
        if (clr)       step.op = OP_CLEAR;
        else if (load) step.op = OP_LOAD;
        else           step.op = OP_SHIFT;
    end
endmodule

// File: rtl/johnson_divn_chain.sv
module johnson_divn_chain
    import johnson_divn_pkg::*;
(
    input  logic       clk,
    input  ring_step_t step,
    output stage_vec_t q
);
    always_ff @(posedge clk) begin
        case (step.op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= step.word;
            default:  q <= {q[STAGES-2:0], step.din};
        endcase
    end
endmodule

// File: rtl/johnson_divn.sv
module johnson_divn
    import johnson_divn_pkg::*;
#(
    parameter int DIV_N = 10
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       load,
    input  logic [4:0] preset,
    output logic [4:0] q,
    output logic       div_out
);
    localparam int K = tap_of(DIV_N);

    stage_vec_t ring_q;
    logic       fb_din;
    ring_step_t step;

    johnson_divn_fb #(.DIV_N(DIV_N)) u_fb (
        .q   (ring_q),
        .din (fb_din)
    );

    johnson_divn_ctrl u_ctrl (
        .clr    (clr),
        .load   (load),
        .preset (preset),
        .din    (fb_din),
        .step   (step)
    );

    johnson_divn_chain u_chain (
        .clk  (clk),
        .step (step),
        .q    (ring_q)
    );

    assign q       = ring_q;
    assign div_out = ring_q[K-1];

endmodule

// File: rtl/johnson_divn_chk.sv
module johnson_divn_chk
    import johnson_divn_pkg::*;
#(
    parameter int DIV_N = 10
) (
    input logic       clk,
    input logic       clr,
    input logic       load,
    input logic [4:0] preset,
    input logic [4:0] q,
    input logic       div_out
);
    localparam int K      = tap_of(DIV_N);
    localparam int SETTLE = K + 1;

    // shift edges since the last clear or load, saturating
    logic [4:0] run_cnt;
    always_ff @(posedge clk) begin
        if (clr || load)          run_cnt <= '0;
        else if (run_cnt != 5'd31) run_cnt <= run_cnt + 5'd1;
    end

    a_r3_clear_zero: assert property (@(posedge clk)
        clr |=> (q == 5'd0));

    a_r4_load_word: assert property (@(posedge clk) disable iff (clr)
        load |=> (q == $past(preset)));

    a_r1_shift_up: assert property (@(posedge clk) disable iff (clr)
        !load |=> (q[4:1] == $past(q[3:0])));

    a_r6_loop_legal: assert property (@(posedge clk) disable iff (clr)
        (int'(run_cnt) >= SETTLE) |-> loop_legal(q, DIV_N));

    a_r5_out_period: assert property (@(posedge clk) disable iff (clr)
        (int'(run_cnt) >= SETTLE + DIV_N) |-> (div_out == $past(div_out, DIV_N)));

endmodule

bind johnson_divn johnson_divn_chk #(.DIV_N(DIV_N)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .load    (load),
    .preset  (preset),
    .q       (q),
    .div_out (div_out)
);

// File: tb/sim_johnson_divn.sv
module sim_johnson_divn;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       clr    = 1'b1;
    logic       load   = 1'b0;
    logic [4:0] preset = 5'd0;

    logic [4:0] q_n    [2:10];
    logic       dout_n [2:10];

    johnson_divn #(.DIV_N(10)) u0 (
        .clk(clk), .clr(clr), .load(load), .preset(preset),
        .q(q_n[10]), .div_out(dout_n[10])
    );

    for (genvar g = 2; g <= 9; g++) begin : g_ratio
        johnson_divn #(.DIV_N(g)) u_cnt (
            .clk(clk), .clr(clr), .load(load), .preset(preset),
            .q(q_n[g]), .div_out(dout_n[g])
        );
    end

    int  errors = 0;
    int  checks = 0;
    int  cyc    = 0;
    bit  done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        int         n;
        logic [4:0] exp_q;
        string      req;
    } item_t;

    item_t sb[$];

    function automatic int hi_len(int n);
        return (n + 1) / 2;
    endfunction

    // stage 1 value u edges after a clear (R2)
    function automatic logic s1(int n, int u);
        if (u < 1) return 1'b0;
        return ((u - 1) % n) < hi_len(n);
    endfunction

    function automatic logic [4:0] after_clear(int n, int t);
        logic [4:0] v;
        for (int i = 0; i < 5; i++) v[i] = s1(n, t - i);
        return v;
    endfunction

    function automatic bit tb_legal(logic [4:0] v, int n);
        int w;
        int ch;
        w = hi_len(n);
        ch = 0;
        for (int i = 0; i + 1 < w; i++) if (v[i] != v[i+1]) ch++;
        if (ch > 1) return 1'b0;
        if ((n % 2 == 1) && ((v & ((5'd1 << w) - 5'd1)) == 5'd0)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, int n, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s ratio=%0d actual=%0d expected=%0d", req, n, act, exp);
        end
    endtask

    task automatic push_all(int t, bit cleared, string req);
        for (int n = 2; n <= 10; n++) begin
            item_t it;
            it.due   = cyc + 1;
            it.n     = n;
            it.exp_q = cleared ? 5'd0 : after_clear(n, t);
            it.req   = req;
            sb.push_back(it);
        end
    endtask

    // monitor: compare due items one step after the falling edge
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            check(q_n[it.n] == it.exp_q, it.req, it.n, q_n[it.n], it.exp_q);
            check(dout_n[it.n] == it.exp_q[hi_len(it.n)-1], "R5 div_out", it.n,
                  dout_n[it.n], it.exp_q[hi_len(it.n)-1]);
        end
    end

    bit hist [2:10][20];

    initial begin
        repeat (2) @(negedge clk);
        // R3: clear wins over load with an all-ones preset word
        push_all(0, 1'b1, "R3 clear");
        clr = 1'b1; load = 1'b1; preset = 5'b11111;
        @(negedge clk);
        // R2 R7 R1: free count from zero, stage words against the ideal sequence
        for (int t = 1; t <= 25; t++) begin
            push_all(t, 1'b0, "R2 R7 sequence");
            clr = 1'b0; load = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        // R4 R1 R6 R5: every start state
        for (int s = 0; s < 32; s++) begin
            load = 1'b1; preset = 5'(s);
            @(negedge clk);
            #2;
            for (int n = 2; n <= 10; n++) check(q_n[n] == 5'(s), "R4 load", n, q_n[n], s);
            load = 1'b0;
            @(negedge clk);
            #2;
            for (int n = 2; n <= 10; n++)
                check(q_n[n][4:1] == 4'(s), "R1 shift", n, q_n[n][4:1], s & 15);
            repeat (5) @(negedge clk);
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                #2;
                for (int n = 2; n <= 10; n++) begin
                    check(tb_legal(q_n[n], n), "R6 recovery", n, q_n[n], 1);
                    hist[n][j] = dout_n[n];
                end
            end
            for (int n = 2; n <= 10; n++) begin
                bit per_ok;
                int ones;
                per_ok = 1'b1;
                ones = 0;
                for (int j = n; j < 20; j++) if (hist[n][j] != hist[n][j-n]) per_ok = 1'b0;
                for (int j = 0; j < n; j++) ones += int'(hist[n][j]);
                check(per_ok, "R5 period", n, per_ok, 1);
                check(ones == hi_len(n), "R5 duty", n, ones, hi_len(n));
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule